// File: doc/BRIEF.md
# Streaming Byte-Framed SPI Slave Port

This block is the receive/transmit engine of an SPI slave port on a microcontroller-style peripheral. The serial clock, data-in and active-low select arrive from an external master. They are brought into a faster system clock domain through flop synchronisers, and the serial clock edges are detected there. Mode 0 timing is used: the incoming bit is taken on the rising serial clock edge, the outgoing bit changes on the falling edge, and data travels most significant bit first. One shift register serves both directions and is also the data register that software reads and writes.

Once select goes low, the port exchanges bytes back to back for as long as select stays low. Byte boundaries come only from a bit counter, so select does not have to toggle between bytes. Software loads the first byte before it enables the port. After each byte it has about half a serial clock period to read the received byte and write the next one. If it writes nothing, the byte just received goes back out on the next byte. A completion flag marks each byte. A sticky collision flag records writes that arrive while a byte is partly shifted.

Top module: `spi_stream_slave`

## Requirements
- R1: A data write while the port is disabled or deselected is accepted: read data shows the written value at once, and the most significant bit appears on MISO (output enable high) once select goes low. Bits then leave most significant bit first, each held from one falling serial clock edge to the next, while MOSI is taken on rising edges.
- R2: Driving select low never sets the byte-complete flag.
- R3: The flag sets on the rising serial clock edge that completes a byte, and only then. The bit counter then wraps to zero and the next byte starts while select is still low.
- R4: If no accepted write happens between the completing rising edge and the next falling edge, the next byte sent on MISO is the byte just received.
- R5: A write in that window becomes the next byte sent, its most significant bit first.
- R6: After a byte completes, read data equals the received byte until the next accepted write or shift; an accepted write replaces it.
- R7: A write while one to seven bits of the current byte have been taken (select low, port enabled) leaves the shift register and MISO untouched and sets the collision flag. The collision flag stays set until the collision-clear strobe.
- R8: Raising select (or clearing enable) resets the bit counter, so the next byte is framed from its own first bit. It also drops the MISO output enable and keeps the shift register contents.
- R9: A read strobe or a write strobe clears the byte-complete flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable |
| sck_in | input | 1 | Serial clock from the master (asynchronous) |
| mosi_in | input | 1 | Serial data from the master (asynchronous) |
| sel_n_in | input | 1 | Active-low select (asynchronous) |
| miso_out | output | 1 | Serial data to the master |
| miso_oe | output | 1 | MISO output enable; low means high impedance |
| wr_stb | input | 1 | Data register write strobe |
| wr_data | input | DATA_W | Data to load |
| rd_stb | input | 1 | Data register read strobe |
| rd_data | output | DATA_W | Shift/data register contents |
| byte_done | output | 1 | Byte-complete flag, also usable as the interrupt |
| wcol_clr | input | 1 | Collision flag read/clear strobe |
| wcol | output | 1 | Sticky write-collision flag |

## Verification
The bench streams several bytes under a select line that stays low throughout, with different patterns in the reload window: read plus write, read only, and write only. These show apart a reloaded transmit byte, an echoed received byte, and which strobe clears the completion flag. One byte carries a mid-byte write, which must not disturb the echoed output and must raise the collision flag. A three-bit partial transfer cut short by select, followed by a full byte, shows whether framing restarts from the counter reset or runs on from the stale count.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;

   typedef struct packed {
      logic sck;
      logic mosi;
      logic sel_n;
   } spi_pins_t;

   localparam spi_pins_t PINS_IDLE = '{sck: 1'b0, mosi: 1'b0, sel_n: 1'b1};

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/spi_stream_sync.sv
module spi_stream_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= RST_VAL;
               else        stg[g] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= RST_VAL;
               else        stg[g] <= stg[g-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_stream_core.sv
module spi_stream_core #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned CNT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              mosi_bit,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] shreg,
   output logic              miso_bit,
   output logic              miso_en,
   output logic              byte_end,
   output logic              wr_collide
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
   localparam int unsigned MSB = DATA_W - 1;

   logic [CNT_W-1:0] cnt;
   logic             wr_accept;

   assign wr_collide = wr_stb & active & (cnt != '0);
   assign wr_accept  = wr_stb & ~wr_collide;
   assign byte_end   = active & sck_rise & (cnt == LAST);

   // bit counter: frames bytes while select stays low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!active)     cnt <= '0;
      else if (sck_rise)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   // shared shift / data register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  shreg <= '0;
      else if (wr_accept)          shreg <= wr_data;
      else if (active && sck_rise) shreg <= {shreg[DATA_W-2:0], mosi_bit};
   end

   // outgoing bit: load drives MSB at once, falling edges advance it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  miso_bit <= 1'b0;
      else if (wr_accept)          miso_bit <= wr_data[MSB];
      else if (active && sck_fall) miso_bit <= shreg[MSB];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) miso_en <= 1'b0;
      else        miso_en <= active;
   end

   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && sck_rise && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

   assert_count_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && sck_rise && cnt == LAST) |=> (cnt == '0));

   assert_collide_keeps_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_collide && !sck_rise) |=> $stable(shreg));

   assert_deselect_resets_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt == '0));

endmodule

// File: rtl/spi_stream_flags.sv
module spi_stream_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic done_set,
   input  logic done_clr,
   input  logic coll_set,
   input  logic coll_clr,
   output logic done_q,
   output logic coll_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        done_q <= 1'b0;
      else if (done_set) done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        coll_q <= 1'b0;
      else if (coll_set) coll_q <= 1'b1;
      else if (coll_clr) coll_q <= 1'b0;
   end

   assert_done_needs_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(done_set));

   assert_coll_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_q && !coll_clr) |=> coll_q);

   assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_clr && !done_set) |=> !done_q);

endmodule

// File: rtl/spi_stream_slave.sv
module spi_stream_slave
   import spi_stream_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              sck_in,
   input  logic              mosi_in,
   input  logic              sel_n_in,
   output logic              miso_out,
   output logic              miso_oe,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] rd_data,
   output logic              byte_done,
   input  logic              wcol_clr,
   output logic              wcol
);

   localparam int unsigned PIN_W = $bits(spi_pins_t);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_stream_slave: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
         $error("spi_stream_slave: SYNC_STAGES below minimum");
      end
   endgenerate

   spi_pins_t pins_raw, pins_s;
   logic      sck_prev, sck_rise, sck_fall, active;
   logic      byte_end, wr_collide;

   assign pins_raw = '{sck: sck_in, mosi: mosi_in, sel_n: sel_n_in};

   spi_stream_sync #(
      .W       (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PINS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= pins_s.sck;
   end

   assign sck_rise = pins_s.sck & ~sck_prev;
   assign sck_fall = ~pins_s.sck & sck_prev;
   assign active   = enable & ~pins_s.sel_n;

   spi_stream_core #(.DATA_W(DATA_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .sck_rise   (sck_rise),
      .sck_fall   (sck_fall),
      .mosi_bit   (pins_s.mosi),
      .wr_stb     (wr_stb),
      .wr_data    (wr_data),
      .shreg      (rd_data),
      .miso_bit   (miso_out),
      .miso_en    (miso_oe),
      .byte_end   (byte_end),
      .wr_collide (wr_collide)
   );

   spi_stream_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .done_set (byte_end),
      .done_clr (rd_stb | wr_stb),
      .coll_set (wr_collide),
      .coll_clr (wcol_clr),
      .done_q   (byte_done),
      .coll_q   (wcol)
   );

   assert_select_no_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pins_s.sel_n) |=> !$rose(byte_done));

   assert_idle_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!active) |-> !miso_oe);

endmodule

// File: tb/spi_stream_slave_test.sv
module spi_stream_slave_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       sck = 1'b0;
   logic       mosi = 1'b0;
   logic       sel_n = 1'b1;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_stb = 1'b0;
   logic       wcol_clr = 1'b0;
   logic       miso_out, miso_oe, byte_done, wcol;
   logic [7:0] rd_data;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;   // 50 MHz

   spi_stream_slave uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .sck_in(sck), .mosi_in(mosi),
      .sel_n_in(sel_n), .miso_out(miso_out), .miso_oe(miso_oe), .wr_stb(wr_stb),
      .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data), .byte_done(byte_done),
      .wcol_clr(wcol_clr), .wcol(wcol)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic pulse_wr(input logic [7:0] v);
      wr_data = v; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic pulse_rd();
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   // Reference model: the byte expected on MISO is the preload, the reload,
   // or the previous received byte, chosen by the caller from R1/R4/R5.
   task automatic xfer(input logic [7:0] tx_in, input logic [7:0] exp_out,
                       input int nbits, input bit do_rd, input bit do_wr,
                       input logic [7:0] wr_val, input int coll_at);
      for (int k = 0; k < nbits; k++) begin
         mosi = tx_in[7-k];
         wait_n(6);
         chk($sformatf("R1/R4/R5 miso bit %0d", 7-k), {miso_oe, miso_out}, {1'b1, exp_out[7-k]});
         chk("R3 no flag before byte end", byte_done, 0);
         if (k == coll_at) begin
            pulse_wr(8'h00);
            chk("R7 collision flag set", wcol, 1);
         end
         wait_n(2);
         sck = 1'b1;
         wait_n(6);
         if (k == 7) begin
            chk("R3 flag at eighth bit", byte_done, 1);
            chk("R6 received byte", rd_data, tx_in);
            if (do_rd) begin
               pulse_rd();
               chk("R9 read clears flag", byte_done, 0);
            end
            if (do_wr) begin
               pulse_wr(wr_val);
               chk("R9 write clears flag", byte_done, 0);
               chk("R6 write replaces received byte", rd_data, wr_val);
            end
         end else begin
            wait_n(2);
         end
         sck = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);
      chk("reset flag", byte_done, 0);
      chk("reset collision", wcol, 0);
      chk("R8 reset no drive", miso_oe, 0);

      // R1: preload while disabled
      pulse_wr(8'hA5);
      chk("R1 preload accepted", rd_data, 8'hA5);
      chk("R1 no collision on preload", wcol, 0);
      enable = 1'b1; sel_n = 1'b0;
      wait_n(6);
      chk("R2 select raises no flag", byte_done, 0);
      chk("R1 MSB driven on select", {miso_oe, miso_out}, 2'b11);

      xfer(8'h3C, 8'hA5, 8, 1, 1, 8'h96, -1);   // R5 reload 96
      xfer(8'hF0, 8'h96, 8, 1, 0, 8'h00, -1);   // read only
      xfer(8'h81, 8'hF0, 8, 0, 1, 8'h69, -1);   // R4 echo F0; write only
      xfer(8'h42, 8'h69, 8, 1, 0, 8'h00, 3);    // R7 mid-byte write ignored

      chk("R7 collision sticky", wcol, 1);
      wcol_clr = 1'b1; @(negedge clk); wcol_clr = 1'b0;
      chk("R7 collision cleared", wcol, 0);

      sel_n = 1'b1;
      wait_n(6);
      chk("R8 deselect drops drive", miso_oe, 0);
      chk("R8 deselect keeps data", rd_data, 8'h42);

      // partial byte then reframe: R8 counter reset
      sel_n = 1'b0;
      wait_n(2);
      xfer(8'hA0, 8'h42, 3, 0, 0, 8'h00, -1);
      wait_n(4);
      sel_n = 1'b1;
      wait_n(6);
      chk("R8 partial keeps shifted data", rd_data, 8'h15);
      sel_n = 1'b0;
      wait_n(6);
      chk("R2 reselect raises no flag", byte_done, 0);
      xfer(8'hE7, 8'h15, 8, 1, 0, 8'h00, -1);   // R4 echo of kept bits, R8 reframe

      finish_run();
   end

endmodule